// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

A memory-mapped parallel I/O peripheral with two identical ports, A and B. Each port holds an output register, a direction register, an input latch and a six-bit control register. A processor reaches them through four register slots chosen by a two-bit select with read and write strobes. Per pin, the direction register decides whether a data read returns the latched external input or the value held in the output register. The output and direction registers are driven straight onto external buses, so a pad ring can build bidirectional pins from them.

Each port also has two control inputs, line 1 and line 2. Both pass through a synchronizer, and their edges are detected on the synchronized level. An edge of the polarity that the control register selects latches a status flag. The flags appear in the top two bits of the control register read, drive a per-port interrupt request through enable bits, and are cleared by a read of that port's data register. Line 2 takes part only while the control register configures it as an input.

The input latch samples the port pins on every clock. A control-line change that is stable before clock edge k sets its flag at edge k+SYNC_STAGES. Register writes take effect at the clock edge that samples the strobe. Read data is combinational from the current select and state.

Top module: `dual_port_pio`

## Requirements
- R1: The select maps slot 0 to port A data/direction, 1 to control A, 2 to port B data/direction and 3 to control B. An access to one port leaves the other port's registers, flags and interrupt unchanged.
- R2: Control bit 2 steers slot 0 (A) or 2 (B): 1 reaches the output register and 0 reaches the direction register, for both reads and writes. `pa_out`/`pb_out` and `pa_dir`/`pb_dir` show those registers.
- R3: A control write stores only data bits 5:0. A control read returns those six bits in bits 5:0.
- R4: Control read bit 7 is the line-1 flag. Bit 6 is the line-2 flag only while line 2 is an input (control bit 5 = 0), and reads 0 otherwise.
- R5: A data read returns, per bit, the input latch where the direction bit is 0 and the output register where it is 1. The input latch samples the pins on every clock.
- R6: A read of the data register (control bit 2 = 1) clears both flags of that port. A read of the direction register clears neither.
- R7: A change of the synchronized line 1 sets the line-1 flag only when its direction matches control bit 1 (1 = rising, 0 = falling). The flag is set SYNC_STAGES clocks after the edge that first samples the change.
- R8: While control bit 5 = 1, line 2 changes set no flag and are not tracked.
- R9: While line 2 is an input, control bit 4 selects its active edge (1 = rising, 0 = falling), with the same timing as line 1.
- R10: A port's interrupt output is (line-1 flag AND control bit 0) OR (line-2 flag AND line 2 is an input AND control bit 3).
- R11: Reset clears all output, input, direction and control registers, the tracked line levels and all flags.
- R12: When a matching edge and a clearing data read fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Register slot select |
| rd | input | 1 | Read strobe (clears flags on data read) |
| wr | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the selected slot |
| pa_in | input | DW | Port A external pins |
| pa_out | output | DW | Port A output register |
| pa_dir | output | DW | Port A direction register (1 = output) |
| a_line1 | input | 1 | Port A control line 1 |
| a_line2 | input | 1 | Port A control line 2 |
| irq_a | output | 1 | Port A interrupt request |
| pb_in | input | DW | Port B external pins |
| pb_out | output | DW | Port B output register |
| pb_dir | output | DW | Port B direction register (1 = output) |
| b_line1 | input | 1 | Port B control line 1 |
| b_line2 | input | 1 | Port B control line 2 |
| irq_b | output | 1 | Port B interrupt request |

## Verification
The bench uses the defaults DW = 8 and SYNC_STAGES = 2. At these values every mixing pattern of input latch and output register can be written as a plain byte. The edge-to-flag latency is also exactly three clocks from the falling edge that drives a line. That fixed latency lets the bench place a line edge in the same cycle as a clearing data read and check that the set wins.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int CTL_W      = 6;
   localparam int B_L1_EN    = 0;
   localparam int B_L1_RISE  = 1;
   localparam int B_DATA_SEL = 2;
   localparam int B_L2_EN    = 3;
   localparam int B_L2_RISE  = 4;
   localparam int B_L2_OUT   = 5;

   typedef enum logic [1:0] {
      SLOT_A_DATA = 2'd0,
      SLOT_A_CTL  = 2'd1,
      SLOT_B_DATA = 2'd2,
      SLOT_B_CTL  = 2'd3
   } slot_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         initial $fatal(1, "pio_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_port.sv
module pio_port
   import pio_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data_slot,
   input  logic          wr_ctl_slot,
   input  logic          rd_data_slot,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] pin_in,
   input  logic          line1_raw,
   input  logic          line2_raw,
   output logic [DW-1:0] port_out,
   output logic [DW-1:0] port_dir,
   output logic [DW-1:0] slot_rdata,
   output logic [DW-1:0] ctl_rdata,
   output logic          irq
);
   logic [CTL_W-1:0] ctl_q;
   logic [DW-1:0]    out_q, dir_q, in_q;
   logic             flag1, flag2, prev1, prev2;
   logic             s1, s2;
   logic             data_sel, l2_input, clr, set1, set2;
   logic [7:0]       ctl_byte;

   pio_sync #(.STAGES(SYNC_STAGES)) u_sync1 (.clk(clk), .rst_n(rst_n), .d(line1_raw), .q(s1));
   pio_sync #(.STAGES(SYNC_STAGES)) u_sync2 (.clk(clk), .rst_n(rst_n), .d(line2_raw), .q(s2));

   assign data_sel = ctl_q[B_DATA_SEL];
   assign l2_input = !ctl_q[B_L2_OUT];
   assign clr      = rd_data_slot && data_sel;
   assign set1     = (s1 != prev1) && (s1 == ctl_q[B_L1_RISE]);
   assign set2     = l2_input && (s2 != prev2) && (s2 == ctl_q[B_L2_RISE]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         out_q <= '0;
         dir_q <= '0;
         in_q  <= '0;
         flag1 <= 1'b0;
         flag2 <= 1'b0;
         prev1 <= 1'b0;
         prev2 <= 1'b0;
      end else begin
         in_q  <= pin_in;
         prev1 <= s1;
         if (l2_input) prev2 <= s2;
         if (wr_ctl_slot) ctl_q <= wdata[CTL_W-1:0];
         if (wr_data_slot) begin
            if (data_sel) out_q <= wdata;
            else          dir_q <= wdata;
         end
         if (set1)     flag1 <= 1'b1;
         else if (clr) flag1 <= 1'b0;
         if (set2)     flag2 <= 1'b1;
         else if (clr) flag2 <= 1'b0;
      end
   end

   assign ctl_byte   = {flag1, flag2 && l2_input, ctl_q};
   assign ctl_rdata  = DW'(ctl_byte);
   assign slot_rdata = data_sel ? ((in_q & ~dir_q) | (out_q & dir_q)) : dir_q;
   assign port_out   = out_q;
   assign port_dir   = dir_q;
   assign irq        = (flag1 && ctl_q[B_L1_EN]) || (flag2 && l2_input && ctl_q[B_L2_EN]);

   AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_slot && data_sel && !set1) |=> !ctl_rdata[7]); // R6
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set1 && rd_data_slot) |=> ctl_rdata[7]); // R12
   AST_L2_OUTPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!l2_input && !flag2) |=> !flag2); // R8
   AST_CTL_LOW_SIX: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl_slot |=> ctl_rdata[5:0] == $past(wdata[5:0])); // R3
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_slot && !data_sel) |=> port_dir == $past(wdata)); // R2
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctl_rdata[7] || ctl_rdata[6])); // R10
   AST_L1_WRONG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (s1 && !prev1 && !ctl_q[B_L1_RISE] && !flag1) |=> !flag1); // R7
endmodule

// File: rtl/dual_port_pio.sv
module dual_port_pio
   import pio_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic          rd,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [DW-1:0] pa_in,
   output logic [DW-1:0] pa_out,
   output logic [DW-1:0] pa_dir,
   input  logic          a_line1,
   input  logic          a_line2,
   output logic          irq_a,
   input  logic [DW-1:0] pb_in,
   output logic [DW-1:0] pb_out,
   output logic [DW-1:0] pb_dir,
   input  logic          b_line1,
   input  logic          b_line2,
   output logic          irq_b
);
   localparam int NPORT = 2;

   logic [NPORT-1:0][DW-1:0] pin_v, out_v, dir_v, slot_v, ctl_v;
   logic [NPORT-1:0]         l1_v, l2_v, irq_v;
   logic                     port_hit_b, ctl_hit;

   generate
      if (DW < 8) begin : g_bad_dw
         initial $fatal(1, "dual_port_pio: DW must be at least 8");
      end
   endgenerate

   assign pin_v = {pb_in, pa_in};
   assign l1_v  = {b_line1, a_line1};
   assign l2_v  = {b_line2, a_line2};

   assign port_hit_b = sel[1];
   assign ctl_hit    = sel[0];

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      logic hit;
      assign hit = (port_hit_b == g[0]);
      pio_port #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_port (
         .clk          (clk),
         .rst_n        (rst_n),
         .wr_data_slot (wr && hit && !ctl_hit),
         .wr_ctl_slot  (wr && hit && ctl_hit),
         .rd_data_slot (rd && hit && !ctl_hit),
         .wdata        (wdata),
         .pin_in       (pin_v[g]),
         .line1_raw    (l1_v[g]),
         .line2_raw    (l2_v[g]),
         .port_out     (out_v[g]),
         .port_dir     (dir_v[g]),
         .slot_rdata   (slot_v[g]),
         .ctl_rdata    (ctl_v[g]),
         .irq          (irq_v[g])
      );
   end

   always_comb begin
      unique case (slot_e'(sel))
         SLOT_A_DATA: rdata = slot_v[0];
         SLOT_A_CTL:  rdata = ctl_v[0];
         SLOT_B_DATA: rdata = slot_v[1];
         SLOT_B_CTL:  rdata = ctl_v[1];
         default:     rdata = '0;
      endcase
   end

   assign pa_out = out_v[0];
   assign pa_dir = dir_v[0];
   assign pb_out = out_v[1];
   assign pb_dir = dir_v[1];
   assign irq_a  = irq_v[0];
   assign irq_b  = irq_v[1];

   AST_B_WRITE_SPARES_A: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel[1]) |=> ($stable(pa_out) && $stable(pa_dir))); // R1
endmodule

// File: tb/dual_port_pio_tb.sv
module dual_port_pio_tb_top;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    sel = '0;
   logic          rd = 1'b0, wr = 1'b0;
   logic [DW-1:0] wdata = '0, rdata;
   logic [DW-1:0] pa_in = '0, pa_out, pa_dir, pb_in = '0, pb_out, pb_dir;
   logic          a_line1 = 1'b0, a_line2 = 1'b0, b_line1 = 1'b0, b_line2 = 1'b0;
   logic          irq_a, irq_b;
   int            checks = 0, failures = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   dual_port_pio #(.DW(DW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir), .a_line1(a_line1), .a_line2(a_line2), .irq_a(irq_a),
      .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .b_line1(b_line1), .b_line2(b_line2), .irq_b(irq_b));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      sel = s; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      sel = s; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [1:0] s, input logic [7:0] exp);
      logic [7:0] v;
      rd_reg(s, v);
      check(req, v, exp);
   endtask

   // drive a line at a falling edge, then let the flag settle (three rising edges)
   task automatic drive_line(input int which, input logic lvl);
      @(negedge clk);
      case (which)
         0: a_line1 = lvl;
         1: a_line2 = lvl;
         2: b_line1 = lvl;
         default: b_line2 = lvl;
      endcase
      repeat (3) @(posedge clk);
   endtask

   task automatic t_reset;
      expect_reg("R11 ddrA", 2'd0, 8'h00);
      expect_reg("R11 ctlA", 2'd1, 8'h00);
      expect_reg("R11 ddrB", 2'd2, 8'h00);
      expect_reg("R11 ctlB", 2'd3, 8'h00);
      check("R11 pa_out", pa_out, 8'h00);
      check("R11 pb_dir", pb_dir, 8'h00);
      check("R11 irq", {6'd0, irq_b, irq_a}, 8'h00);
   endtask

   task automatic t_map_and_mix;
      logic [7:0] v;
      wr_reg(2'd0, 8'hF0);
      check("R2 dir write", pa_dir, 8'hF0);
      wr_reg(2'd1, 8'hFF);
      expect_reg("R3 ctl top bits", 2'd1, 8'h3F);
      wr_reg(2'd1, 8'h04);
      wr_reg(2'd0, 8'h5A);
      check("R2 out write", pa_out, 8'h5A);
      check("R2 dir kept", pa_dir, 8'hF0);
      pa_in = 8'h3C;
      expect_reg("R5 mix A", 2'd0, 8'h5C);
      wr_reg(2'd1, 8'h00);
      expect_reg("R2 dir read", 2'd0, 8'hF0);
      wr_reg(2'd3, 8'h00);
      wr_reg(2'd2, 8'h0F);
      wr_reg(2'd3, 8'h04);
      wr_reg(2'd2, 8'hA5);
      check("R1 pb_out", pb_out, 8'hA5);
      check("R1 pb_dir", pb_dir, 8'h0F);
      check("R1 pa_out untouched", pa_out, 8'h5A);
      check("R1 pa_dir untouched", pa_dir, 8'hF0);
      pb_in = 8'hFF;
      expect_reg("R5 mix B", 2'd2, 8'hF5);
      rd_reg(2'd1, v);
      check("R1 ctlA untouched", v, 8'h00);
   endtask

   task automatic t_line1;
      logic [7:0] v;
      wr_reg(2'd1, 8'h07);
      drive_line(0, 1'b1);
      expect_reg("R7 rising sets", 2'd1, 8'h87);
      check("R10 irq l1", {7'd0, irq_a}, 8'h01);
      rd_reg(2'd0, v);
      expect_reg("R6 data read clears", 2'd1, 8'h07);
      check("R10 irq drops", {7'd0, irq_a}, 8'h00);
      drive_line(0, 1'b0);
      expect_reg("R7 falling ignored", 2'd1, 8'h07);
      wr_reg(2'd1, 8'h05);
      drive_line(0, 1'b1);
      expect_reg("R7 rising ignored", 2'd1, 8'h05);
      drive_line(0, 1'b0);
      expect_reg("R7 falling sets", 2'd1, 8'h85);
      wr_reg(2'd1, 8'h01);
      expect_reg("R6 dir read value", 2'd0, 8'hF0);
      expect_reg("R6 dir read keeps flag", 2'd1, 8'h81);
      wr_reg(2'd1, 8'h05);
      rd_reg(2'd0, v);
      expect_reg("R6 cleared", 2'd1, 8'h05);
      wr_reg(2'd1, 8'h06);
      drive_line(0, 1'b1);
      expect_reg("R10 flag no enable", 2'd1, 8'h86);
      check("R10 irq masked", {7'd0, irq_a}, 8'h00);
      wr_reg(2'd1, 8'h04);
      rd_reg(2'd0, v);
   endtask

   task automatic t_line2;
      logic [7:0] v;
      wr_reg(2'd1, 8'h2C);
      drive_line(1, 1'b1);
      expect_reg("R8 output mode ignores", 2'd1, 8'h2C);
      check("R8 irq quiet", {7'd0, irq_a}, 8'h00);
      drive_line(1, 1'b0);
      wr_reg(2'd1, 8'h1C);
      drive_line(1, 1'b1);
      expect_reg("R9 rising sets", 2'd1, 8'h5C);
      check("R10 irq l2", {7'd0, irq_a}, 8'h01);
      rd_reg(2'd0, v);
      expect_reg("R6 l2 cleared", 2'd1, 8'h1C);
      drive_line(1, 1'b0);
      expect_reg("R9 falling ignored", 2'd1, 8'h1C);
      wr_reg(2'd1, 8'h14);
      drive_line(1, 1'b1);
      expect_reg("R9 flag no enable", 2'd1, 8'h54);
      check("R10 l2 masked", {7'd0, irq_a}, 8'h00);
      wr_reg(2'd1, 8'h2C);
      expect_reg("R4 hidden as output", 2'd1, 8'h2C);
      check("R10 l2 output no irq", {7'd0, irq_a}, 8'h00);
      rd_reg(2'd0, v);
      wr_reg(2'd1, 8'h0C);
      expect_reg("R9 no spurious edge", 2'd1, 8'h0C);
      drive_line(1, 1'b0);
      expect_reg("R9 falling sets", 2'd1, 8'h4C);
      check("R10 irq l2 fall", {7'd0, irq_a}, 8'h01);
      rd_reg(2'd0, v);
   endtask

   task automatic t_port_b;
      logic [7:0] v;
      wr_reg(2'd3, 8'h07);
      drive_line(2, 1'b1);
      expect_reg("R1 ctlB flag", 2'd3, 8'h87);
      check("R1 irq_b", {7'd0, irq_b}, 8'h01);
      check("R1 irq_a independent", {7'd0, irq_a}, 8'h00);
      expect_reg("R1 ctlA independent", 2'd1, 8'h0C);
      rd_reg(2'd2, v);
      check("R6 irq_b cleared", {7'd0, irq_b}, 8'h00);
   endtask

   task automatic t_collision;
      logic [7:0] v;
      wr_reg(2'd1, 8'h05);
      @(negedge clk);
      a_line1 = 1'b0;
      repeat (2) @(posedge clk);
      rd_reg(2'd0, v);
      expect_reg("R12 set wins", 2'd1, 8'h85);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map_and_mix();
      t_line1();
      t_line2();
      t_port_b();
      t_collision();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule